// File: doc/BRIEF.md
# Instruction Exception Classifier

This block runs alongside the decode stage of a small in-order RISC core. For every issued instruction it decides whether that instruction raises an exception by itself and, if so, which kind: a trap, a slot-illegal instruction, a general-illegal instruction, or an integer-divide fault. The decoder supplies pre-decoded class flags and the two divide operands. A status bit reports when the floating-point unit is in module standby.

Whether an instruction is legal can depend on where it sits. The block keeps its own registered flag that marks the instruction issued directly after a delayed branch. In that position, any instruction that writes the PC, uses a 32-bit encoding, restores a register bank or divides becomes slot-illegal. The result is registered and appears one clock after the issue strobe as a single-cycle pulse with a 2-bit type code.

Top module: `iexc_classifier`

## Requirements
- R1: An issued undefined instruction that is not in a delay slot raises a general-illegal exception, type code 2'b10.
- R2: An issued undefined instruction in a delay slot raises a slot-illegal exception, type code 2'b01.
- R3: In a delay slot, an instruction that writes the PC, a delayed branch, or a trap instruction raises slot-illegal (2'b01).
- R4: In a delay slot, a 32-bit-encoded instruction, a register-bank restore, a signed divide or an unsigned divide raises slot-illegal (2'b01).
- R5: An FPU-class instruction counts as undefined while the FPU standby bit is high, so it is classified by R1 or R2. With standby low it raises no exception.
- R6: A signed or unsigned divide whose divisor is zero raises an integer-divide exception, type code 2'b11.
- R7: A signed divide of 32'h8000_0000 by 32'hFFFF_FFFF (-1) raises integer-divide (2'b11). An unsigned divide with the same operands raises nothing.
- R8: A trap instruction outside a delay slot raises a trap exception, type code 2'b00.
- R9: The delay-slot flag is set by an issued delayed branch that raises no exception. It holds through cycles without issue and is cleared by the next issued instruction.
- R10: Precedence is slot-illegal first, then general-illegal, then trap or divide. Divide faults are reported only for instructions that are otherwise legal.
- R11: The exception strobe is a one-cycle pulse one clock after an issue-valid cycle. It never follows a cycle without issue-valid.
- R12: Synchronous active-high reset clears the delay-slot flag and holds the strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_vld_i | input | 1 | An instruction issues this cycle |
| undef_i | input | 1 | Instruction is undefined code |
| fpu_op_i | input | 1 | FPU instruction or FPU-related CPU instruction |
| dbranch_i | input | 1 | Delayed branch instruction |
| pc_write_i | input | 1 | Instruction writes the PC |
| wide_i | input | 1 | 32-bit encoded instruction |
| bank_restore_i | input | 1 | Register-bank restore instruction |
| sdiv_i | input | 1 | Signed divide |
| udiv_i | input | 1 | Unsigned divide |
| trap_i | input | 1 | Trap instruction |
| dividend_i | input | W (32) | Divide dividend |
| divisor_i | input | W (32) | Divide divisor |
| fpu_standby_i | input | 1 | FPU is in module standby |
| exc_vld_o | output | 1 | Exception pulse, one clock after issue |
| exc_type_o | output | 2 | 00 trap, 01 slot-illegal, 10 general-illegal, 11 integer-divide |

## Verification
Each classification result appears on the clock edge after the issue cycle, because a single output register sits between the class flags and the ports. The delay-slot flag changes on that same edge, so it affects only the next issued instruction. The driver sets inputs on the falling edge and pushes one expected item per cycle. The monitor pops items two nanoseconds after each rising edge, so each comparison lines up with exactly one issue cycle, idle and reset cycles included. Delay-slot cases are built as two-instruction pairs, or with idle gaps or a reset between them, so the flag's set, hold and clear timing is observed only through later results.

// File: rtl/iexc_pkg.sv
package iexc_pkg;
  typedef enum logic [1:0] {
    EXC_TRAP = 2'b00,
    EXC_SLOT = 2'b01,
    EXC_GEN  = 2'b10,
    EXC_DIV  = 2'b11
  } exc_code_e;

  typedef struct packed {
    logic undef;
    logic fpu;
    logic dbr;
    logic pcw;
    logic wide;
    logic bank;
    logic sdiv;
    logic udiv;
    logic trap;
  } insn_cls_t;
endpackage

// File: rtl/iexc_div_check.sv
module iexc_div_check #(
  parameter int W = 32
) (
  input  logic         sdiv,
  input  logic         udiv,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         fault
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MINUS_ONE = {W{1'b1}};

  logic zero_div;
  logic ovf;

  always_comb begin
    zero_div = (divisor == '0);
    ovf      = (dividend == MOST_NEG) && (divisor == MINUS_ONE);
    fault    = ((sdiv || udiv) && zero_div) || (sdiv && ovf);
  end
endmodule

// File: rtl/iexc_slot_tracker.sv
module iexc_slot_tracker (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  input  logic dbranch,
  input  logic exc_now,
  output logic in_slot
);
  always_ff @(posedge clk) begin
    if (rst) begin
      in_slot <= 1'b0;
    end else if (issue) begin
      in_slot <= dbranch && !exc_now;
    end
  end
endmodule

// File: rtl/iexc_resolve.sv
module iexc_resolve
  import iexc_pkg::*;
(
  input  insn_cls_t cls,
  input  logic      standby,
  input  logic      in_slot,
  input  logic      div_fault,
  output logic      hit,
  output exc_code_e code
);
  logic eff_undef;
  logic slot_bad;

  always_comb begin
    eff_undef = cls.undef || (cls.fpu && standby);
    slot_bad  = in_slot && (eff_undef || cls.dbr || cls.pcw || cls.trap ||
                            cls.wide || cls.bank || cls.sdiv || cls.udiv);
    hit  = 1'b1;
    code = EXC_TRAP;
    if (slot_bad) begin
      code = EXC_SLOT;
    end else if (eff_undef) begin
      code = EXC_GEN;
    end else if (cls.trap) begin
      code = EXC_TRAP;
    end else if (div_fault) begin
      code = EXC_DIV;
    end else begin
      hit = 1'b0;
    end
  end
endmodule

// File: rtl/iexc_classifier.sv
module iexc_classifier
  import iexc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         issue_vld_i,
  input  logic         undef_i,
  input  logic         fpu_op_i,
  input  logic         dbranch_i,
  input  logic         pc_write_i,
  input  logic         wide_i,
  input  logic         bank_restore_i,
  input  logic         sdiv_i,
  input  logic         udiv_i,
  input  logic         trap_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  input  logic         fpu_standby_i,
  output logic         exc_vld_o,
  output logic [1:0]   exc_type_o
);
  insn_cls_t cls;
  logic      div_fault;
  logic      hit;
  exc_code_e code;
  logic      slot_q;
  logic      exc_now;

  always_comb begin
    cls.undef = undef_i;
    cls.fpu   = fpu_op_i;
    cls.dbr   = dbranch_i;
    cls.pcw   = pc_write_i;
    cls.wide  = wide_i;
    cls.bank  = bank_restore_i;
    cls.sdiv  = sdiv_i;
    cls.udiv  = udiv_i;
    cls.trap  = trap_i;
    exc_now   = issue_vld_i && hit;
  end

  iexc_div_check #(.W(W)) u_div (
    .sdiv     (sdiv_i),
    .udiv     (udiv_i),
    .dividend (dividend_i),
    .divisor  (divisor_i),
    .fault    (div_fault)
  );

  iexc_resolve u_res (
    .cls       (cls),
    .standby   (fpu_standby_i),
    .in_slot   (slot_q),
    .div_fault (div_fault),
    .hit       (hit),
    .code      (code)
  );

  iexc_slot_tracker u_slot (
    .clk     (clk),
    .rst     (rst),
    .issue   (issue_vld_i),
    .dbranch (dbranch_i),
    .exc_now (exc_now),
    .in_slot (slot_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_vld_o  <= 1'b0;
      exc_type_o <= 2'b00;
    end else begin
      exc_vld_o  <= exc_now;
      exc_type_o <= code;
    end
  end
endmodule

// File: rtl/iexc_classifier_chk.sv
module iexc_classifier_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         issue_vld_i,
  input logic         undef_i,
  input logic         fpu_op_i,
  input logic         dbranch_i,
  input logic         trap_i,
  input logic         sdiv_i,
  input logic [W-1:0] divisor_i,
  input logic         fpu_standby_i,
  input logic         slot_q,
  input logic         exc_vld_o,
  input logic [1:0]   exc_type_o
);
  logic undef_eff;
  assign undef_eff = undef_i || (fpu_op_i && fpu_standby_i);

  a_r11_qualified: assert property (@(posedge clk) disable iff (rst)
    !issue_vld_i |=> !exc_vld_o);

  a_r2_slot_undef: assert property (@(posedge clk) disable iff (rst)
    issue_vld_i && slot_q && undef_eff |=> exc_vld_o && exc_type_o == 2'b01);

  a_r1_gen_undef: assert property (@(posedge clk) disable iff (rst)
    issue_vld_i && !slot_q && undef_eff |=> exc_vld_o && exc_type_o == 2'b10);

  a_r8_trap: assert property (@(posedge clk) disable iff (rst)
    issue_vld_i && !slot_q && !undef_eff && trap_i |=> exc_vld_o && exc_type_o == 2'b00);

  a_r6_div_zero: assert property (@(posedge clk) disable iff (rst)
    issue_vld_i && !slot_q && !undef_eff && !trap_i && sdiv_i && divisor_i == '0
    |=> exc_vld_o && exc_type_o == 2'b11);

  a_r9_slot_set: assert property (@(posedge clk) disable iff (rst)
    issue_vld_i && !slot_q && !undef_eff && dbranch_i && !trap_i |=> slot_q);

  a_r9_slot_hold: assert property (@(posedge clk) disable iff (rst)
    !issue_vld_i |=> $stable(slot_q));

  a_r12_reset: assert property (@(posedge clk)
    rst |=> !exc_vld_o && !slot_q);
endmodule

bind iexc_classifier iexc_classifier_chk #(.W(W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .issue_vld_i   (issue_vld_i),
  .undef_i       (undef_i),
  .fpu_op_i      (fpu_op_i),
  .dbranch_i     (dbranch_i),
  .trap_i        (trap_i),
  .sdiv_i        (sdiv_i),
  .divisor_i     (divisor_i),
  .fpu_standby_i (fpu_standby_i),
  .slot_q        (slot_q),
  .exc_vld_o     (exc_vld_o),
  .exc_type_o    (exc_type_o)
);

// File: tb/iexc_classifier_bench.sv
module iexc_classifier_bench;
  localparam int W = 32;
  localparam logic [8:0] C_UNDEF = 9'h100, C_FPU = 9'h080, C_DBR = 9'h040,
                         C_PCW = 9'h020, C_WIDE = 9'h010, C_BANK = 9'h008,
                         C_SDIV = 9'h004, C_UDIV = 9'h002, C_TRAP = 9'h001;

  typedef struct {
    logic       vld;
    logic [1:0] typ;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic issue = 1'b0;
  logic [8:0] cls = '0;
  logic [W-1:0] dvd = '0, dvs = '0;
  logic stby = 1'b0;
  logic exc_vld;
  logic [1:0] exc_type;

  item_t q[$];
  int vectors = 0, fails = 0;
  logic model_slot = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  iexc_classifier #(.W(W)) u_iexc_classifier (
    .clk(clk), .rst(rst), .issue_vld_i(issue),
    .undef_i(cls[8]), .fpu_op_i(cls[7]), .dbranch_i(cls[6]), .pc_write_i(cls[5]),
    .wide_i(cls[4]), .bank_restore_i(cls[3]), .sdiv_i(cls[2]), .udiv_i(cls[1]),
    .trap_i(cls[0]), .dividend_i(dvd), .divisor_i(dvs), .fpu_standby_i(stby),
    .exc_vld_o(exc_vld), .exc_type_o(exc_type)
  );

  task automatic step(input logic iv, input logic [8:0] c, input logic [W-1:0] a,
                      input logic [W-1:0] b, input logic sb, input string tag);
    item_t it;
    logic und, slotbad, dz, ovf;
    @(negedge clk);
    issue = iv; cls = c; dvd = a; dvs = b; stby = sb;
    it.tag = tag; it.vld = 1'b0; it.typ = 2'b00;
    und = c[8] || (c[7] && sb);
    slotbad = model_slot && (und || (c[6:0] != '0));
    dz = (c[2] || c[1]) && (b == '0);
    ovf = c[2] && (a == 32'h8000_0000) && (b == 32'hFFFF_FFFF);
    if (iv) begin
      if (slotbad)       begin it.vld = 1; it.typ = 2'b01; end
      else if (und)      begin it.vld = 1; it.typ = 2'b10; end
      else if (c[0])     begin it.vld = 1; it.typ = 2'b00; end
      else if (dz || ovf) begin it.vld = 1; it.typ = 2'b11; end
      model_slot = c[6] && !it.vld;
    end
    q.push_back(it);
  endtask

  task automatic ins(input logic [8:0] c, input string tag);
    step(1'b1, c, 32'd7, 32'd3, 1'b0, tag);
  endtask

  task automatic do_reset(input int n);
    item_t it;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rst = 1'b1; issue = 1'b0; cls = '0;
      it.vld = 0; it.typ = 0; it.tag = "R12";
      model_slot = 1'b0;
      q.push_back(it);
    end
    @(negedge clk);
    rst = 1'b0;
    it.vld = 0; it.typ = 0; it.tag = "R12";
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        vectors++;
        if (exc_vld !== e.vld || (e.vld && exc_type !== e.typ)) begin
          fails++;
          $display("FAIL %s: vld/type actual %0b/%02b expected %0b/%02b",
                   e.tag, exc_vld, exc_type, e.vld, e.typ);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : driver
    do_reset(3);
    step(0, '0, 0, 0, 0, "R11");
    step(0, C_UNDEF, 0, 0, 0, "R11");           // not issued: no pulse
    ins(C_UNDEF, "R1");
    ins(C_TRAP, "R8");
    step(1, C_UDIV, 32'd5, 32'd0, 0, "R6");
    step(1, C_SDIV, 32'd0, 32'd0, 0, "R6");
    step(1, C_SDIV, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R7");
    step(1, C_UDIV, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R7");
    step(1, C_SDIV, 32'h8000_0000, 32'hFFFF_FFFE, 0, "R7");
    step(1, C_FPU, 0, 1, 1, "R5");
    step(1, C_FPU, 0, 1, 0, "R5");
    ins(C_DBR, "R9"); ins(C_UNDEF, "R2");
    ins(C_DBR, "R9"); step(1, C_FPU, 0, 1, 1, "R5");
    ins(C_DBR, "R9"); ins(C_PCW, "R3");
    ins(C_DBR, "R9"); ins(C_TRAP, "R3");
    ins(C_DBR, "R9"); ins(C_DBR | C_PCW, "R3");
    ins(C_UNDEF, "R9");                          // slot cleared by exception
    ins(C_DBR, "R9"); ins(C_WIDE, "R4");
    ins(C_DBR, "R9"); ins(C_BANK, "R4");
    ins(C_DBR, "R9"); ins(C_SDIV, "R4");
    ins(C_DBR, "R9"); ins(C_UDIV, "R4");
    ins(C_DBR, "R9"); step(0, '0, 0, 0, 0, "R9"); step(0, '0, 0, 0, 0, "R9");
    ins(C_UNDEF, "R9");                          // held across idle
    ins(C_DBR, "R9"); ins('0, "R9"); ins(C_UNDEF, "R9");
    ins(C_DBR, "R10"); step(1, C_SDIV, 0, 0, 0, "R10");
    ins(C_UNDEF | C_TRAP, "R10");
    ins(C_DBR, "R10"); ins(C_UNDEF | C_TRAP, "R10");
    step(1, C_UNDEF | C_SDIV, 0, 0, 0, "R10");
    ins(C_DBR, "R12");
    do_reset(2);
    ins(C_UNDEF, "R12");
    ins(C_UNDEF, "R11"); step(0, '0, 0, 0, 0, "R11");
    step(0, '0, 0, 0, 0, "R11");
    @(posedge clk); @(posedge clk); #3;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule